// File: doc/BRIEF.md
# Persistence Integration Filter with Instability Flag

This block screens an overhead field that arrives once per frame, such as a status bit group or a whole byte. A field is accepted only when it has persisted. Each time the caller raises the occurrence strobe, the block compares the presented value with two others: the value it currently holds, and the raw value it saw at the previous occurrence. A new value replaces the held one only after it has arrived unchanged on a run of consecutive occurrences. Isolated glitches therefore never reach the output.

The block tracks a separate condition for an input that never settles. An occurrence is counted as erratic when it matches neither the held value nor the previous raw value. After a long enough unbroken run of erratic occurrences, the unstable flag rises. It stays high until the held value is seen again or a new value is accepted. Each update of the held value is announced by a one-cycle change pulse. Extracting the field from the frame is left to the surrounding logic.

Top module: `persist_filter`

## Requirements
- R1: A value that differs from the held value is accepted after it has been presented on ACCEPT_RUN (default 5) consecutive occurrences. It appears on `value_o` in the cycle after the strobe of the last of those occurrences, and not before.
- R2: An occurrence whose value differs from the current candidate restarts the acceptance run, so the earlier partial run is lost.
- R3: An occurrence adds to the instability run only if its value differs from both the held value and the previous raw value. An occurrence that repeats the previous raw value, while still differing from the held value, resets the instability run to zero.
- R4: `unstable_o` rises in the cycle after the UNSTABLE_RUN-th (default 8) consecutive erratic occurrence, and not after fewer.
- R5: `value_o` changes only when a value is accepted. Between acceptances it holds its value.
- R6: Cycles with `occ_i` low change no counter and no output, whatever `data_i` carries.
- R7: An occurrence carrying the held value clears both runs and drops `unstable_o`.
- R8: Accepting a new value drops `unstable_o`. The flag otherwise stays high while erratic or repeated values keep arriving.
- R9: `changed_o` is high for exactly the one cycle in which `value_o` has just taken a new value.
- R10: While `rst` is high, `value_o` is zero, `unstable_o` and `changed_o` are low, and both runs are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| occ_i | input | 1 | Marks a cycle in which `data_i` carries a new occurrence of the field |
| data_i | input | W | Raw field value for this occurrence |
| value_o | output | W | Integrated (held) field value |
| changed_o | output | 1 | One-cycle pulse after `value_o` is updated |
| unstable_o | output | 1 | Input has been erratic for UNSTABLE_RUN consecutive occurrences |

## Verification
The bench builds the filter with its default parameters: an 8-bit field, an acceptance run of five and an instability run of eight. With these values every boundary can be reached in a few dozen occurrences. The bench checks the fourth and fifth occurrence of an acceptance, and the seventh and eighth erratic occurrence. The 8-bit width also leaves room for distinct alternating patterns, so the bench can tell a repeat of the previous value from a return to the held value.

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int W            = 8,
  parameter int ACCEPT_RUN   = 5,
  parameter int UNSTABLE_RUN = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         occ_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] value_o,
  output logic         changed_o,
  output logic         unstable_o
);
  localparam int RW = $clog2(ACCEPT_RUN + 1);
  localparam int IW = $clog2(UNSTABLE_RUN + 1);

  logic [W-1:0]  prev_q;
  logic [RW-1:0] run_q;
  logic [IW-1:0] inst_q;

  wire hit_stored = (data_i == value_o);
  wire hit_prev   = (data_i == prev_q);
  wire erratic    = !hit_stored && !hit_prev;

  wire [RW-1:0] run_nxt  = hit_prev ? run_q + 1'b1 : RW'(1);
  wire          accept   = occ_i && !hit_stored && (run_nxt == RW'(ACCEPT_RUN));
  wire [IW-1:0] inst_nxt = (inst_q == IW'(UNSTABLE_RUN)) ? inst_q : inst_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      value_o    <= '0;
      prev_q     <= '0;
      run_q      <= '0;
      inst_q     <= '0;
      changed_o  <= 1'b0;
      unstable_o <= 1'b0;
    end else begin
      changed_o <= 1'b0;
      if (occ_i) begin
        prev_q <= data_i;
        if (hit_stored) begin
          run_q      <= '0;
          inst_q     <= '0;
          unstable_o <= 1'b0;
        end else if (accept) begin
          value_o    <= data_i;
          changed_o  <= 1'b1;
          run_q      <= '0;
          inst_q     <= '0;
          unstable_o <= 1'b0;
        end else begin
          run_q  <= run_nxt;
          inst_q <= erratic ? inst_nxt : '0;
          if (erratic && inst_nxt == IW'(UNSTABLE_RUN))
            unstable_o <= 1'b1;
        end
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !occ_i |=> ($stable(value_o) && $stable(unstable_o) && !changed_o)); // R6
  AST_CHANGE_MEANS_NEW: assert property (@(posedge clk) disable iff (rst)
    changed_o |-> (value_o != $past(value_o))); // R9
  AST_VALUE_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    !changed_o |-> $stable(value_o)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    changed_o |=> !changed_o); // R9
  AST_UNSTABLE_ONSET: assert property (@(posedge clk) disable iff (rst)
    $rose(unstable_o) |-> ($past(inst_q) == IW'(UNSTABLE_RUN - 1))); // R4
  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (occ_i && hit_stored) |=> (!unstable_o && run_q == '0 && inst_q == '0)); // R7
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    changed_o |-> !unstable_o); // R8
endmodule

// File: tb/persist_filter_bench.sv
`timescale 1ns/1ps
module persist_filter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       occ = 1'b0;
  logic [7:0] data = '0;
  logic [7:0] value;
  logic       changed, unstable;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  persist_filter #(.W(8), .ACCEPT_RUN(5), .UNSTABLE_RUN(8)) u_persist_filter (
    .clk(clk), .rst(rst), .occ_i(occ), .data_i(data),
    .value_o(value), .changed_o(changed), .unstable_o(unstable)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic occur(input logic [7:0] d);
    @(negedge clk); occ = 1'b1; data = d;
    @(negedge clk); occ = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "value", value, 0);
    chk("R10", "unstable", unstable, 0);
    chk("R10", "changed", changed, 0);
  endtask

  task automatic t_accept();
    for (int i = 0; i < 4; i++) begin
      occur(8'h5A);
      chk("R1", "value before run", value, 0);
      chk("R1", "changed before run", changed, 0);
    end
    occur(8'h5A);
    chk("R1", "value after run", value, 8'h5A);
    chk("R9", "changed pulse", changed, 1);
    @(negedge clk);
    chk("R9", "changed drops", changed, 0);
    chk("R5", "value held", value, 8'h5A);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 4; i++) occur(8'h33);
    occur(8'h44);
    for (int i = 0; i < 4; i++) occur(8'h33);
    chk("R2", "no accept after broken run", value, 8'h5A);
    occur(8'h33);
    chk("R2", "accept after full run", value, 8'h33);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) occur(8'h77);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); data = 8'(i * 37 + 1);
      chk("R6", "value during idle", value, 8'h33);
    end
    occur(8'h77);
    chk("R6", "run kept across idle", value, 8'h77);
  endtask

  task automatic t_unstable();
    for (int i = 0; i < 7; i++) occur((i % 2) ? 8'h02 : 8'h01);
    chk("R4", "unstable after 7", unstable, 0);
    occur(8'h02);
    chk("R4", "unstable after 8", unstable, 1);
    chk("R5", "value kept while unstable", value, 8'h77);
  endtask

  task automatic t_match_clear();
    occur(8'h77);
    chk("R7", "stored value clears flag", unstable, 0);
    for (int i = 0; i < 4; i++) occur(8'h09);
    occur(8'h77);
    for (int i = 0; i < 4; i++) occur(8'h09);
    chk("R7", "stored value resets run", value, 8'h77);
    for (int i = 0; i < 7; i++) occur((i % 2) ? 8'h02 : 8'h01);
    occur(8'h77);
    for (int i = 0; i < 7; i++) occur((i % 2) ? 8'h02 : 8'h01);
    chk("R7", "stored value resets instability", unstable, 0);
  endtask

  task automatic t_prev_break();
    occur(8'h77);
    for (int i = 0; i < 4; i++) occur((i % 2) ? 8'h02 : 8'h01);
    occur(8'h02);
    for (int i = 0; i < 7; i++) occur((i % 2) ? 8'h02 : 8'h01);
    chk("R3", "repeat broke instability run", unstable, 0);
    occur(8'h02);
    chk("R3", "eight erratic after break", unstable, 1);
  endtask

  task automatic t_clear_on_accept();
    for (int i = 0; i < 4; i++) occur(8'h99);
    chk("R8", "flag held while repeating", unstable, 1);
    occur(8'h99);
    chk("R8", "accept clears flag", unstable, 0);
    chk("R1", "accepted after flag", value, 8'h99);
    chk("R9", "pulse on accept", changed, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_accept();
    t_restart();
    t_idle();
    t_unstable();
    t_match_clear();
    t_prev_break();
    t_clear_on_accept();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule